// File: doc/BRIEF.md
# Signed-Count Bidirectional Barrel Shifter

This block shifts a 40-bit datapath by up to 16 places in either direction within one clock cycle. A signed shift count sets both the direction and the distance. A positive count moves the operand toward bit 0. A negative count moves it toward bit 39. A zero count passes the operand through unchanged. Right shifts can fill from the sign bit or with zeros. Left shifts always fill with zeros.

The operand comes from one of three sources: either of two 40-bit accumulators, or a 16-bit data word. A data word is placed in the 40-bit datapath according to the shift direction. For a right shift it sits in the middle field, so bits that leave the bottom of the word can still be observed. For a left shift or a zero count it sits in the low field. The block registers two results: the full 40-bit datapath, and a 16-bit word taken from the field that matches the direction.

Top module: `shf_barrel_top`

## Requirements
- R1: Both outputs are registered. A set of inputs sampled at one rising clock edge appears on the outputs right after that edge. While the synchronous active-low reset is low at an edge, both outputs become zero.
- R2: `src_sel` picks the operand. 2'b00 selects accumulator A, 2'b01 selects accumulator B, and 2'b10 or 2'b11 select the 16-bit data word.
- R3: A positive count shifts right, a negative count shifts left, and a zero count leaves the operand unmodified.
- R4: `shift_cnt` is a 6-bit two's-complement value (-32 to +31). Counts above +16 act as +16, and counts below -16 act as -16.
- R5: On a right shift with `arith_en` high, bit 39 of the operand fills the vacated upper bits. With `arith_en` low, those bits are filled with zero.
- R6: On a left shift, the vacated low bits are zero, and bits shifted beyond bit 39 are discarded.
- R7: For a right shift, a data word is placed at bits 31:16. Bits 15:0 are zero. Bits 39:32 are copies of word bit 15 when `arith_en` is high and zero otherwise. For a left shift or a zero count, the word is placed at bits 15:0 and all other bits are zero.
- R8: `word_result` equals bits 31:16 of the shifted datapath after a right shift. After a left shift or a zero count it equals bits 15:0.
- R9: `acc_result` always carries the full 40-bit shifted datapath, including for data-word operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 2 | Operand source select |
| acc_a | input | 40 | Accumulator A operand |
| acc_b | input | 40 | Accumulator B operand |
| bus_word | input | 16 | Data word operand |
| shift_cnt | input | 6 | Signed shift count, positive means right |
| arith_en | input | 1 | High for sign fill on right shifts |
| acc_result | output | 40 | Registered 40-bit shifted datapath |
| word_result | output | 16 | Registered 16-bit word result |

## Verification
The bench targets the count limits of ±16 and the saturating counts ±17, +31 and -32. A design that wrapped or truncated the count would shift by a small or wrong distance at these values. Negative data words under arithmetic and logical right shifts check the placement of the word and its extension bits. An error there would show up as leading ones after a logical shift, or as a lost sign after an arithmetic one. Left shifts of a word by 16 must return an all-zero word. A zero count must pass each source through untouched, which catches a design that takes the word from the wrong field or mixes up the two accumulators.

// File: rtl/shf_pkg.sv
// Package: shared types for the bidirectional barrel shifter.
// Assumes: a two-bit source select and a three-way direction decode.
package shf_pkg;

    // Operand source encoding; both upper codes pick the data word.
    typedef enum logic [1:0] {
        SRC_ACC_A   = 2'b00,
        SRC_ACC_B   = 2'b01,
        SRC_WORD    = 2'b10,
        SRC_WORD_HI = 2'b11
    } shf_src_e;

    // Shift direction after count decode.
    typedef enum logic [1:0] {
        DIR_NONE  = 2'b00,
        DIR_RIGHT = 2'b01,
        DIR_LEFT  = 2'b10
    } shf_dir_e;

endpackage

// File: rtl/shf_count_decode.sv
// Module: shf_count_decode
// Turns a signed shift count into a direction and a saturated magnitude.
// Assumes: MAX_SH is representable as a positive CNT_W-bit signed value
// and fits in AMT_W bits.
module shf_count_decode
    import shf_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int MAX_SH = 16,
    parameter int AMT_W  = $clog2(MAX_SH + 1)
) (
    input  logic signed [CNT_W-1:0] cnt_i,
    output shf_dir_e                dir_o,
    output logic [AMT_W-1:0]        amt_o
);

    int cnt_int;
    int mag;

    // Purpose: classify the sign of the count and clamp its magnitude.
    always_comb begin
        cnt_int = int'(cnt_i);
        if (cnt_int > 0) begin
            dir_o = DIR_RIGHT;
            mag   = (cnt_int > MAX_SH) ? MAX_SH : cnt_int;
        end else if (cnt_int < 0) begin
            dir_o = DIR_LEFT;
            mag   = (-cnt_int > MAX_SH) ? MAX_SH : -cnt_int;
        end else begin
            dir_o = DIR_NONE;
            mag   = 0;
        end
        amt_o = AMT_W'(mag);
    end

endmodule

// File: rtl/shf_operand_mux.sv
// Module: shf_operand_mux
// Selects the operand and places a data word according to the direction.
// Assumes: WORD_R_LSB + WORD_W <= ACC_W.
module shf_operand_mux
    import shf_pkg::*;
#(
    parameter int ACC_W      = 40,
    parameter int WORD_W     = 16,
    parameter int WORD_R_LSB = 16
) (
    input  shf_src_e          src_i,
    input  logic [ACC_W-1:0]  acc_a_i,
    input  logic [ACC_W-1:0]  acc_b_i,
    input  logic [WORD_W-1:0] word_i,
    input  shf_dir_e          dir_i,
    input  logic              arith_i,
    output logic [ACC_W-1:0]  opnd_o
);

    localparam int EXT_LSB = WORD_R_LSB + WORD_W;

    logic [ACC_W-1:0] word_right;
    logic [ACC_W-1:0] word_low;
    logic             ext_bit;

    // Purpose: build the right-shift placement with an optional sign extension.
    always_comb begin
        ext_bit    = arith_i & word_i[WORD_W-1];
        word_right = '0;
        word_right[WORD_R_LSB +: WORD_W] = word_i;
        for (int i = EXT_LSB; i < ACC_W; i++) begin
            word_right[i] = ext_bit;
        end
    end

    // Purpose: build the low placement used for left shifts and zero counts.
    always_comb begin
        word_low = '0;
        word_low[WORD_W-1:0] = word_i;
    end

    // Purpose: pick the operand for the shifter.
    always_comb begin
        unique case (src_i)
            SRC_ACC_A: opnd_o = acc_a_i;
            SRC_ACC_B: opnd_o = acc_b_i;
            default:   opnd_o = (dir_i == DIR_RIGHT) ? word_right : word_low;
        endcase
    end

endmodule

// File: rtl/shf_core.sv
// Module: shf_core
// Logarithmic shifter: one stage per bit of the amount, each stage moving by
// a power of two in the decoded direction.
// Assumes: 2**(AMT_W-1) < W and the amount is zero when the direction is none.
module shf_core
    import shf_pkg::*;
#(
    parameter int W     = 40,
    parameter int AMT_W = 5
) (
    input  logic [W-1:0]     data_i,
    input  shf_dir_e         dir_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             arith_i,
    output logic [W-1:0]     data_o
);

    logic [W-1:0] stage [0:AMT_W];
    logic         fill_bit;
    logic         go_right;

    // Purpose: fix the fill value for vacated upper bits.
    always_comb begin
        go_right = (dir_i == DIR_RIGHT);
        fill_bit = go_right & arith_i & data_i[W-1];
    end

    assign stage[0] = data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int D = 1 << s;
        logic [W-1:0] moved;

        // Purpose: shift this stage by its power of two in the chosen direction.
        always_comb begin
            if (go_right) begin
                moved = {{D{fill_bit}}, stage[s][W-1:D]};
            end else begin
                moved = {stage[s][W-1-D:0], {D{1'b0}}};
            end
        end

        assign stage[s+1] = amt_i[s] ? moved : stage[s];
    end

    assign data_o = stage[AMT_W];

endmodule

// File: rtl/shf_barrel_top.sv
// Module: shf_barrel_top
// Single-cycle signed-count barrel shifter with registered 40-bit and word
// results. Assumes: synchronous active-low reset, inputs stable at the edge.
module shf_barrel_top
    import shf_pkg::*;
#(
    parameter int ACC_W      = 40,
    parameter int WORD_W     = 16,
    parameter int CNT_W      = 6,
    parameter int MAX_SH     = 16,
    parameter int WORD_R_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic [ACC_W-1:0]  acc_a,
    input  logic [ACC_W-1:0]  acc_b,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [CNT_W-1:0]  shift_cnt,
    input  logic              arith_en,
    output logic [ACC_W-1:0]  acc_result,
    output logic [WORD_W-1:0] word_result
);

    localparam int AMT_W = $clog2(MAX_SH + 1);

    shf_dir_e         dir_w;
    logic [AMT_W-1:0] amt_w;
    logic [ACC_W-1:0] opnd_w;
    logic [ACC_W-1:0] shifted_w;
    logic [WORD_W-1:0] word_w;

    shf_count_decode #(
        .CNT_W (CNT_W),
        .MAX_SH(MAX_SH),
        .AMT_W (AMT_W)
    ) u_decode (
        .cnt_i(signed'(shift_cnt)),
        .dir_o(dir_w),
        .amt_o(amt_w)
    );

    shf_operand_mux #(
        .ACC_W     (ACC_W),
        .WORD_W    (WORD_W),
        .WORD_R_LSB(WORD_R_LSB)
    ) u_mux (
        .src_i  (shf_src_e'(src_sel)),
        .acc_a_i(acc_a),
        .acc_b_i(acc_b),
        .word_i (bus_word),
        .dir_i  (dir_w),
        .arith_i(arith_en),
        .opnd_o (opnd_w)
    );

    shf_core #(
        .W    (ACC_W),
        .AMT_W(AMT_W)
    ) u_core (
        .data_i (opnd_w),
        .dir_i  (dir_w),
        .amt_i  (amt_w),
        .arith_i(arith_en),
        .data_o (shifted_w)
    );

    // Purpose: take the word from the field matching the direction.
    always_comb begin
        if (dir_w == DIR_RIGHT) begin
            word_w = shifted_w[WORD_R_LSB +: WORD_W];
        end else begin
            word_w = shifted_w[WORD_W-1:0];
        end
    end

    // Purpose: register both results, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_result  <= '0;
            word_result <= '0;
        end else begin
            acc_result  <= shifted_w;
            word_result <= word_w;
        end
    end

endmodule

// File: rtl/shf_barrel_chk.sv
// Module: shf_barrel_chk
// Assertion checker bound to shf_barrel_top; observes ports and decode outputs.
module shf_barrel_chk
    import shf_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 6,
    parameter int MAX_SH = 16,
    parameter int AMT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        src_sel,
    input logic [ACC_W-1:0]  acc_a,
    input logic [WORD_W-1:0] bus_word,
    input logic [CNT_W-1:0]  shift_cnt,
    input logic              arith_en,
    input logic [ACC_W-1:0]  acc_result,
    input logic [WORD_W-1:0] word_result,
    input shf_dir_e          dir_w,
    input logic [AMT_W-1:0]  amt_w
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_result == '0 && word_result == '0));

    assert_amount_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(amt_w) <= MAX_SH);

    assert_zero_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_cnt == '0) |-> (dir_w == DIR_NONE && amt_w == '0));

    assert_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b00 && shift_cnt == '0) |=> (acc_result == $past(acc_a)));

    assert_logic_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel[1] == 1'b0 && $signed(shift_cnt) > 0 && !arith_en)
        |=> (acc_result[ACC_W-1] == 1'b0));

    assert_arith_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b00 && $signed(shift_cnt) > 0 && arith_en)
        |=> (acc_result[ACC_W-1] == $past(acc_a[ACC_W-1])));

    assert_left_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(shift_cnt) < 0) |=> (acc_result[0] == 1'b0));

    assert_word_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel[1] && shift_cnt == '0) |=> (word_result == $past(bus_word)));

endmodule

bind shf_barrel_top shf_barrel_chk #(
    .ACC_W (ACC_W),
    .WORD_W(WORD_W),
    .CNT_W (CNT_W),
    .MAX_SH(MAX_SH),
    .AMT_W (AMT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .acc_a      (acc_a),
    .bus_word   (bus_word),
    .shift_cnt  (shift_cnt),
    .arith_en   (arith_en),
    .acc_result (acc_result),
    .word_result(word_result),
    .dir_w      (dir_w),
    .amt_w      (amt_w)
);

// File: tb/shf_barrel_top_tb.sv
module shf_barrel_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic [39:0] acc_a = '0;
    logic [39:0] acc_b = '0;
    logic [15:0] bus_word = '0;
    logic [5:0]  shift_cnt = '0;
    logic        arith_en = 1'b0;
    logic [39:0] acc_result;
    logic [15:0] word_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shf_barrel_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .acc_a      (acc_a),
        .acc_b      (acc_b),
        .bus_word   (bus_word),
        .shift_cnt  (shift_cnt),
        .arith_en   (arith_en),
        .acc_result (acc_result),
        .word_result(word_result)
    );

    // Reference model from the requirements: returns {word, acc}.
    function automatic logic [55:0] model(input logic [1:0] s, input logic [39:0] a,
                                          input logic [39:0] b, input logic [15:0] w,
                                          input logic [5:0] c, input logic ar);
        int n;
        logic [39:0] op;
        logic [39:0] res;
        logic [15:0] wd;
        n = int'($signed(c));
        if (n > 16) n = 16;
        if (n < -16) n = -16;
        if (s == 2'b00) op = a;
        else if (s == 2'b01) op = b;
        else if (n > 0) op = {(ar && w[15]) ? 8'hFF : 8'h00, w, 16'h0000};
        else op = {24'h0, w};
        if (n > 0) res = ar ? 40'($signed(op) >>> n) : (op >> n);
        else res = op << (-n);
        wd = (n > 0) ? res[31:16] : res[15:0];
        return {wd, res};
    endfunction

    task automatic check(input string tag, input logic [39:0] exp_acc, input logic [15:0] exp_wd);
        checks++;
        if (acc_result !== exp_acc || word_result !== exp_wd) begin
            errors++;
            $display("FAIL %s: acc=%h word=%h expected acc=%h word=%h",
                     tag, acc_result, word_result, exp_acc, exp_wd);
        end
    endtask

    task automatic apply(input string tag, input logic [1:0] s, input logic [39:0] a,
                         input logic [39:0] b, input logic [15:0] w,
                         input logic [5:0] c, input logic ar);
        logic [55:0] e;
        @(negedge clk);
        src_sel = s; acc_a = a; acc_b = b; bus_word = w; shift_cnt = c; arith_en = ar;
        e = model(s, a, b, w, c, ar);
        @(negedge clk);
        check(tag, e[39:0], e[55:40]);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: acc=%h word=%h expected completion", acc_result, word_result);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset clears outputs even with live inputs.
        acc_a = 40'hFF_FFFF_FFFF; shift_cnt = 6'd3;
        repeat (3) @(negedge clk);
        check("R1 reset", '0, '0);
        rst_n = 1'b1;

        // R3 zero count pass-through, R2 source selection.
        apply("R3 R2 zero count acc A", 2'b00, 40'h12_3456_789A, 40'hAB_CDEF_0123, 16'h5A5A, 6'd0, 1'b1);
        apply("R2 zero count acc B", 2'b01, 40'h12_3456_789A, 40'hAB_CDEF_0123, 16'h5A5A, 6'd0, 1'b0);
        apply("R2 R7 R8 zero count word", 2'b10, 40'h1, 40'h2, 16'h8001, 6'd0, 1'b1);
        apply("R2 word alt code", 2'b11, 40'h1, 40'h2, 16'hC3C3, 6'd4, 1'b0);

        // R5 arithmetic versus logical right.
        apply("R5 arith right 4", 2'b00, 40'h80_0000_00F0, 40'h0, 16'h0, 6'd4, 1'b1);
        apply("R5 logic right 4", 2'b00, 40'h80_0000_00F0, 40'h0, 16'h0, 6'd4, 1'b0);
        apply("R5 arith right 16", 2'b01, 40'h0, 40'hF0_1234_5678, 16'h0, 6'd16, 1'b1);

        // R4 saturation.
        apply("R4 right 17 saturates", 2'b00, 40'hC0_0000_0001, 40'h0, 16'h0, 6'd17, 1'b1);
        apply("R4 right 31 saturates", 2'b00, 40'h7F_FFFF_FFFF, 40'h0, 16'h0, 6'd31, 1'b0);
        apply("R4 left -32 saturates", 2'b00, 40'h00_0000_ABCD, 40'h0, 16'h0, 6'h20, 1'b0);
        apply("R4 left -17 saturates", 2'b01, 40'h0, 40'h12_3456_789A, 16'h0, 6'h2F, 1'b0);

        // R6 left shifts discard overflow.
        apply("R6 left -16", 2'b00, 40'hAB_CDEF_1234, 40'h0, 16'h0, 6'h30, 1'b1);
        apply("R6 left -1", 2'b00, 40'h80_0000_0001, 40'h0, 16'h0, 6'h3F, 1'b1);

        // R7 R8 word placement.
        apply("R7 R8 word arith right 1", 2'b10, 40'h0, 40'h0, 16'h8003, 6'd1, 1'b1);
        apply("R7 R8 word logic right 1", 2'b10, 40'h0, 40'h0, 16'h8003, 6'd1, 1'b0);
        apply("R7 R8 word arith right 16", 2'b10, 40'h0, 40'h0, 16'hFFFF, 6'd16, 1'b1);
        apply("R7 R8 R9 word left 16", 2'b10, 40'h0, 40'h0, 16'hBEEF, 6'h30, 1'b0);
        apply("R7 R8 word left 3", 2'b11, 40'h0, 40'h0, 16'h1234, 6'h3D, 1'b1);

        // R9 and general coverage with random stimulus.
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            apply("R9 random", 2'($urandom), {8'($urandom), 32'($urandom)},
                  {8'($urandom), 32'($urandom)}, 16'($urandom), 6'($urandom), 1'($urandom));
        end

        // R1: reset mid-run clears outputs.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", '0, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule